// File: doc/BRIEF.md
# Link-Up Stability Qualifier

This block sits between a raw link-status indication and the logic that acts on the link state. It declares the link up only after the raw indication has stayed high, without a single low sample, for a stability window chosen by a 3-bit period code. A free-running microsecond tick input measures the window. The eight window lengths grow non-linearly, from zero up to two seconds. A loss of link is passed through at once, with no filtering.

The period code is held in a small configuration register. It loads from a write strobe and takes code 2 (1 ms) after reset. Rewriting the code with a different value while a qualification is running starts that qualification again under the new window. Each transition of the qualified output is marked by a pulse that lasts one clock.

Top module: `link_stab_qual`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `link_up` = 0 and `link_chg` = 0, and the active period code is 2.
- R2: The window in microsecond ticks is chosen by the period code: code 0 → 0, 1 → 500, 2 → 1000, 3 → 64000, 4 → 256000, 5 → 512000, 6 → 1000000, 7 → 2000000. Only three bits are decoded, so no code lies outside 0..7.
- R3: When `link_raw` is first sampled high at edge S and stays high, `link_up` rises at the clock edge that follows the edge sampling the N-th `us_tick`, counting from S. N is the window of the active code.
- R4: A single low sample of `link_raw` before `link_up` rises clears the accumulated ticks. Counting starts again from zero at the next high sample.
- R5: `link_up` falls at the same clock edge that samples `link_raw` low, with no filtering.
- R6: With code 0, `link_up` follows `link_raw` with a delay of one clock.
- R7: `link_chg` is high for exactly the one cycle in which `link_up` takes a new value, and at no other time.
- R8: A write (`cfg_wr` = 1) of a code that differs from the active code while qualifying clears the count. Counting starts again on the next cycle under the new window. A write of the same code has no effect on the timing. A write while `link_up` is high leaves `link_up` unchanged.
- R9: Only cycles with `us_tick` high advance the window. If `us_tick` stays low, `link_up` never rises for a code other than 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_raw | input | 1 | Unfiltered link status, synchronous to `clk` |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| cfg_wr | input | 1 | Write strobe for the period code |
| cfg_code | input | 3 | Period code to load when `cfg_wr` is high |
| link_up | output | 1 | Qualified link status |
| link_chg | output | 1 | One-cycle pulse on every change of `link_up` |

## Verification
The hardest situation to reach from the ports is a code rewrite that lands in the middle of a running window. It must restart the count, while a rewrite with the same value must not. The stimulus raises the link, waits a few hundred ticks, and then writes a new code on a known edge. The scoreboard expects the rise exactly one full new window after the cycle following that edge. A second run does the same with an identical code and expects the original timing. Tick gating is exercised by strobing `us_tick` only every third cycle, and also by holding it low for a long stretch, so that cycles and ticks separate in the expected edge.

// File: rtl/lsq_pkg.sv
// Shared definitions for the link stability qualifier.
// Assumes one tick is TICK_US microseconds; window lengths are whole ticks.
package lsq_pkg;

    typedef enum logic [1:0] {
        LS_DOWN = 2'd0,
        LS_QUAL = 2'd1,
        LS_UP   = 2'd2
    } lsq_state_t;

    localparam int unsigned LSQ_MAX_US = 2000000;

    // Window length in microseconds for a 3-bit period code.
    function automatic int unsigned window_us(input logic [2:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 500;
            3'd2:    return 1000;
            3'd3:    return 64000;
            3'd4:    return 256000;
            3'd5:    return 512000;
            3'd6:    return 1000000;
            default: return 2000000;
        endcase
    endfunction

    // Window length in ticks for a tick period of tick_us microseconds.
    function automatic int unsigned window_ticks(input logic [2:0] code,
                                                 input int unsigned tick_us);
        return window_us(code) / tick_us;
    endfunction

endpackage

// File: rtl/lsq_cfg.sv
// Period code register. Loads on a write strobe and resets to RESET_CODE.
// Flags a write whose value differs from the held code.
module lsq_cfg #(
    parameter logic [2:0] RESET_CODE = 3'd2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] wr_code,
    output logic [2:0] code_q,
    output logic       code_chg
);

    // Holds the active period code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= RESET_CODE;
        else if (wr)
            code_q <= wr_code;
    end

    // A write counts as a change only when the value differs.
    always_comb code_chg = wr && (wr_code != code_q);

endmodule

// File: rtl/lsq_timer.sv
// Stability window counter. Counts ticks while run is high and clears
// when run is low. Saturates at the window limit of the active code.
// Assumes run is low for at least one cycle whenever the code changes.
module lsq_timer #(
    parameter int unsigned TICK_US = 1,
    parameter int unsigned CNT_W   = 21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [2:0] code,
    output logic       done
);

    localparam int unsigned N_CODES = 8;

    logic [CNT_W-1:0] lim_tab [N_CODES];
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;

    // One constant limit per period code.
    for (genvar g = 0; g < N_CODES; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'(lsq_pkg::window_ticks(3'(g), TICK_US));
    end

    // Picks the limit of the active code.
    always_comb limit = lim_tab[code];

    // Tick counter: cleared when idle, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (tick && (cnt_q < limit))
            cnt_q <= cnt_q + 1'b1;
    end

    // Window complete while still running.
    always_comb done = run && (cnt_q >= limit);

endmodule

// File: rtl/lsq_fsm.sv
// Qualification state machine. Drops at once when the raw link falls and
// rises when the timer reports a complete window. Registers the change pulse.
module lsq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic done,
    input  logic code_chg,
    output logic run,
    output logic up,
    output logic chg
);

    import lsq_pkg::*;

    lsq_state_t state_q, state_d;

    // Next state from raw level, window result and code rewrite.
    always_comb begin
        if (!raw)
            state_d = LS_DOWN;
        else if (state_q == LS_UP)
            state_d = LS_UP;
        else if (done && !code_chg)
            state_d = LS_UP;
        else
            state_d = LS_QUAL;
    end

    // The timer runs only while qualifying without a code rewrite.
    always_comb run = raw && (state_q != LS_UP) && !code_chg;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LS_DOWN;
        else
            state_q <= state_d;
    end

    // Change pulse: high in the cycle after a transition of the up state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chg <= 1'b0;
        else
            chg <= (state_d == LS_UP) != (state_q == LS_UP);
    end

    // Qualified output.
    always_comb up = (state_q == LS_UP);

endmodule

// File: rtl/link_stab_qual.sv
// Link-up stability qualifier top. Joins the period register, the window
// timer and the state machine. Assumes link_raw and us_tick are already
// synchronous to clk.
module link_stab_qual #(
    parameter int unsigned TICK_US    = 1,
    parameter logic [2:0]  RESET_CODE = 3'd2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_raw,
    input  logic       us_tick,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_code,
    output logic       link_up,
    output logic       link_chg
);

    localparam int unsigned MAX_TICKS = lsq_pkg::LSQ_MAX_US / TICK_US;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    logic [2:0] active_code;
    logic       code_chg;
    logic       run;
    logic       done;

    lsq_cfg #(.RESET_CODE(RESET_CODE)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wr_code  (cfg_code),
        .code_q   (active_code),
        .code_chg (code_chg)
    );

    lsq_timer #(.TICK_US(TICK_US), .CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (us_tick),
        .code  (active_code),
        .done  (done)
    );

    lsq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (link_raw),
        .done     (done),
        .code_chg (code_chg),
        .run      (run),
        .up       (link_up),
        .chg      (link_chg)
    );

endmodule

// File: rtl/lsq_checker.sv
// Protocol checker for link_stab_qual. Keeps its own tick span counter to
// judge each rise of the qualified output.
module lsq_checker #(
    parameter int unsigned TICK_US = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       link_raw,
    input logic       us_tick,
    input logic       cfg_wr,
    input logic [2:0] cfg_code,
    input logic [2:0] active_code,
    input logic       link_up,
    input logic       link_chg
);

    localparam int unsigned SPAN_MAX = lsq_pkg::LSQ_MAX_US / TICK_US;

    int unsigned span;
    logic        span_ok;
    logic        rewrite;

    always_comb rewrite = cfg_wr && (cfg_code != active_code);
    always_comb span_ok = span >= lsq_pkg::window_ticks(active_code, TICK_US);

    // Ticks seen since the raw link last went high or the code was rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_raw || link_up || rewrite)
            span <= 0;
        else if (us_tick && span < SPAN_MAX)
            span <= span + 1;
    end

    // R1: reset forces output low, no pulse, default code.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!link_up && !link_chg && active_code == 3'd2));

    // R5: a low raw sample forces the output low on the next cycle.
    a_r5_fast_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !link_raw |=> !link_up);

    // R3: a rise needs the raw link high in the deciding cycle.
    a_r3_rise_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(link_raw));

    // R3: a rise needs a full window of ticks.
    a_r3_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(span_ok));

    // R6: with code 0 the output follows a high raw sample one cycle later.
    a_r6_zero_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (active_code == 3'd0 && link_raw && !cfg_wr) |=> link_up);

    // R7: every change of the output carries a pulse.
    a_r7_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up != $past(link_up)) |-> link_chg);

    // R7: no pulse without a change.
    a_r7_pulse_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        link_chg |-> (link_up != $past(link_up)));

endmodule

bind link_stab_qual lsq_checker #(.TICK_US(TICK_US)) u_lsq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_raw    (link_raw),
    .us_tick     (us_tick),
    .cfg_wr      (cfg_wr),
    .cfg_code    (cfg_code),
    .active_code (active_code),
    .link_up     (link_up),
    .link_chg    (link_chg)
);

// File: tb/test_link_stab_qual.sv
`timescale 1ns/1ps
module test_link_stab_qual;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_raw = 1'b0;
    logic       us_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_code = 3'd0;
    logic       link_up;
    logic       link_chg;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int tick_div = 1;
    bit tick_en = 1'b1;
    bit mon_on = 1'b0;
    bit cur_lvl = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int    stamp;
        bit    lvl;
        string req;
    } exp_t;

    exp_t exp_q[$];

    link_stab_qual i_link_stab_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_raw (link_raw),
        .us_tick  (us_tick),
        .cfg_wr   (cfg_wr),
        .cfg_code (cfg_code),
        .link_up  (link_up),
        .link_chg (link_chg)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Tick source: edge number cyc+1 sees a tick when it is a multiple of tick_div.
    always @(negedge clk) us_tick = tick_en && (((cyc + 1) % tick_div) == 0);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Edge at which the output should rise: one edge after the l-th tick from edge s.
    function automatic int up_edge(input int s, input int l);
        int n = 0;
        if (l == 0) return s;
        for (int e = s; e < s + 10000000; e++) begin
            if ((e % tick_div) == 0) begin
                n++;
                if (n == l) return e + 1;
            end
        end
        return -1;
    endfunction

    task automatic push(input int stamp, input bit lvl, input string req);
        exp_t it;
        it.stamp = stamp;
        it.lvl = lvl;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_code(input logic [2:0] c);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_code = c;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Raise the raw link; returns the first edge that samples it high.
    task automatic raise(output int s);
        @(negedge clk);
        link_raw = 1'b1;
        s = cyc + 1;
    endtask

    // Drop the raw link and expect an immediate fall (R5).
    task automatic drop_expect();
        @(negedge clk);
        link_raw = 1'b0;
        push(cyc + 1, 1'b0, "R5");
        wait_cycles(3);
    endtask

    // Monitor: pops one expected item per change pulse, checks level otherwise.
    always @(negedge clk) begin
        if (mon_on) begin
            if (link_chg) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected change pulse, level", int'(link_up), int'(cur_lvl));
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check(cyc == it.stamp, it.req, "change edge", cyc, it.stamp);
                    check(link_up == it.lvl, it.req, "new level", int'(link_up), int'(it.lvl));
                end
                cur_lvl = link_up;
            end else if (link_up != cur_lvl) begin
                check(1'b0, "R7", "level change without pulse", int'(link_up), int'(cur_lvl));
                cur_lvl = link_up;
            end
        end
    end

    initial begin
        int s, s2, w;
        wait_cycles(4);
        // R1: outputs during and right after reset
        check(link_up == 1'b0, "R1", "link_up in reset", int'(link_up), 0);
        check(link_chg == 1'b0, "R1", "link_chg in reset", int'(link_chg), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        wait_cycles(2);
        check(link_up == 1'b0, "R1", "link_up after reset", int'(link_up), 0);

        // R1, R2, R3: default code 2 gives a 1000-tick window
        raise(s);
        push(up_edge(s, 1000), 1'b1, "R1");
        wait_cycles(1010);
        check(link_up == 1'b1, "R3", "up after default window", int'(link_up), 1);
        drop_expect();

        // R4: a glitch restarts the 500-tick window
        set_code(3'd1);
        raise(s);
        wait_cycles(300);
        link_raw = 1'b0;
        @(negedge clk);
        check(link_up == 1'b0, "R4", "no rise before glitch", int'(link_up), 0);
        link_raw = 1'b1;
        s2 = cyc + 1;
        push(up_edge(s2, 500), 1'b1, "R4");
        wait_cycles(510);
        drop_expect();

        // R6, R7: code 0 follows raw one cycle later, back-to-back pulses
        set_code(3'd0);
        raise(s);
        push(s, 1'b1, "R6");
        @(negedge clk);
        link_raw = 1'b0;
        push(cyc + 1, 1'b0, "R7");
        wait_cycles(3);
        raise(s);
        push(s, 1'b1, "R6");
        wait_cycles(3);
        drop_expect();

        // R8: a different code written mid-window restarts under the new window
        set_code(3'd1);
        raise(s);
        wait_cycles(200);
        cfg_wr = 1'b1;
        cfg_code = 3'd2;
        w = cyc + 1;
        push(up_edge(w + 1, 1000), 1'b1, "R8");
        @(negedge clk);
        cfg_wr = 1'b0;
        wait_cycles(1010);
        // R8: a write while up leaves the output alone
        set_code(3'd0);
        wait_cycles(10);
        check(link_up == 1'b1, "R8", "up kept after write", int'(link_up), 1);
        drop_expect();

        // R8: rewriting the same code keeps the original timing
        set_code(3'd1);
        raise(s);
        push(up_edge(s, 500), 1'b1, "R8");
        wait_cycles(100);
        set_code(3'd1);
        wait_cycles(420);
        drop_expect();

        // R9: ticks every third cycle stretch the window in cycles
        tick_div = 3;
        raise(s);
        push(up_edge(s, 500), 1'b1, "R9");
        wait_cycles(1520);
        drop_expect();
        tick_div = 1;

        // R9: with no ticks the output never rises
        tick_en = 1'b0;
        raise(s);
        wait_cycles(2000);
        check(link_up == 1'b0, "R9", "no rise without ticks", int'(link_up), 0);
        @(negedge clk);
        link_raw = 1'b0;
        wait_cycles(3);
        tick_en = 1'b1;

        // R2: code 3 is a 64000-tick window
        set_code(3'd3);
        raise(s);
        push(up_edge(s, 64000), 1'b1, "R2");
        wait_cycles(63990);
        check(link_up == 1'b0, "R2", "still down before 64000 ticks", int'(link_up), 0);
        wait_cycles(20);
        check(link_up == 1'b1, "R2", "up after 64000 ticks", int'(link_up), 1);
        drop_expect();

        wait_cycles(5);
        check(exp_q.size() == 0, "R3", "expected changes left over", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run is reported as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 200000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule